// File: doc/BRIEF.md
# Configurable Serial Audio Receiver Port

This block receives two-channel PCM audio from a three-wire link made of a bit clock, a word clock that tells the two channels apart, and one serial data line. It turns the stream into a parallel left sample and a parallel right sample. Both are presented together, with a one-cycle valid strobe, after each complete frame. The port runs entirely on one system clock. It samples the serial clock and word clock as ordinary inputs and finds their edges in the system clock domain.

Static configuration inputs select the operating mode. In slave mode the port follows externally driven clocks. In master mode it generates them itself from a programmable divider, with 64 bit clocks per frame. The other settings choose the sample resolution, whether data is aligned to the start of a word-clock phase or to its end, whether the first data bit is delayed by one bit clock, the active edge of the bit clock, and which word-clock level means the left channel. Taken together, these settings cover left-justified, right-justified and I2S-style framing with one format engine.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is held and just after it is released, `sampleValid` is low and `leftOut` and `rightOut` are zero. In slave mode `sclkOut` and `wclkOut` are held low.
- R2: With `cfgRightJust`=0 and `cfgDelay`=0, the sample is formed from the first `cfgBits` bits of a word-clock phase, MSB first. Any bits that follow them in the same phase have no effect on the output.
- R3: With `cfgRightJust`=0 and `cfgDelay`=1, the bit in the first slot of a phase is ignored and the sample starts in the second slot (I2S-style framing).
- R4: With `cfgRightJust`=1, the sample is formed from the last `cfgBits` bits received before the word clock changes. Any earlier bits of the phase, and `cfgDelay`, have no effect.
- R5: `cfgBits` takes values 1 to 24. Each output is the received value sign-extended from bit `cfgBits`-1 to 24 bits.
- R6: With `cfgSclkInv`=0, data and the word clock are sampled on rising edges of the bit clock pin. With `cfgSclkInv`=1 they are sampled on falling edges.
- R7: With `cfgWclkInv`=0, a low word clock marks the left channel. With `cfgWclkInv`=1, a high word clock marks the left channel.
- R8: Each frame is a left phase followed by a right phase. It produces exactly one single-cycle `sampleValid` pulse, raised when the first bit of the next left phase is sampled, and both outputs change only on that pulse. After reset, no pulse is raised until a complete left phase has followed a word-clock change.
- R9: In slave mode, capture stays correct when the bit clock pauses between bits and when the two phases of a frame hold different numbers of bit clocks. Each level of the bit clock must last at least two system clock cycles.
- R10: In master mode, each level of the bit clock pin lasts `cfgDiv`+1 system clock cycles (`cfgDiv` of 1 or more). The word clock changes together with a non-sampling edge of the bit clock, every 32 bit clocks.
- R11: In master mode, the port captures `sdIn` with its own generated clocks using the same format rules as in slave mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgMaster | input | 1 | 1: port generates bit and word clocks; 0: clocks are inputs |
| cfgDiv | input | 8 | Master bit clock half period minus one, in system clocks |
| cfgBits | input | 5 | Sample resolution in bits, 1 to 24 |
| cfgRightJust | input | 1 | 1: data ends at the word-clock change; 0: data starts at it |
| cfgDelay | input | 1 | Left-justified only: first data bit one bit clock late |
| cfgSclkInv | input | 1 | 1: sample on falling bit clock edges |
| cfgWclkInv | input | 1 | 1: high word clock marks the left channel |
| sclkIn | input | 1 | Bit clock from an external master |
| wclkIn | input | 1 | Word clock from an external master |
| sdIn | input | 1 | Serial data |
| sclkOut | output | 1 | Generated bit clock (master mode, else low) |
| wclkOut | output | 1 | Generated word clock (master mode, else low) |
| leftOut | output | 24 | Left sample, sign-extended |
| rightOut | output | 24 | Right sample, sign-extended |
| sampleValid | output | 1 | One-cycle strobe when a new sample pair is presented |

## Verification
The bound checker checks four properties on every cycle:
- the valid strobe never lasts two cycles;
- the outputs hold steady between strobes;
- each presented sample is a correct sign extension for the configured resolution;
- in master mode, the word clock moves only on a non-sampling bit clock edge, and the bit clock never toggles on consecutive cycles.

Only the bench scenarios can show that the right bits land in the samples. Those scenarios cover:
- each justification and delay choice;
- both clock polarities;
- paused bit clocks and unequal phase lengths;
- the exact master divider period and the 32-bit-clock phase length.

// File: rtl/sarx_pkg.sv
package sarx_pkg;
  // Strobes from the framing control to the sample datapath, valid for one system clock.
  typedef struct packed {
    logic tick;        // sampling edge of the bit clock
    logic phaseStart;  // this tick is slot 0 of a new word-clock phase
    logic endValid;    // the phase that just closed was fully observed
    logic endedRight;  // the phase that just closed carried the right channel
    logic shiftBit;    // the bit of this tick belongs to the sample
  } sarxStrobe_t;
endpackage

// File: rtl/sarx_ctrl.sv
module sarx_ctrl
  import sarx_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int BITS_W      = 5,
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_BITS  = 64,
  parameter int SLOT_W      = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgMaster,
  input  logic [DIV_W-1:0]  cfgDiv,
  input  logic [BITS_W-1:0] cfgBits,
  input  logic              cfgRightJust,
  input  logic              cfgDelay,
  input  logic              cfgSclkInv,
  input  logic              cfgWclkInv,
  input  logic              sclkIn,
  input  logic              wclkIn,
  input  logic              sdIn,
  output logic              sclkOut,
  output logic              wclkOut,
  output logic              sdBit,
  output sarxStrobe_t       strobe
);
  localparam int POS_W = $clog2(FRAME_BITS);

  // Master clock generator: the bit clock toggles every cfgDiv+1 cycles.
  // The word clock is the top bit of the bit position counter.
  logic [DIV_W-1:0] divCnt;
  logic             genBck;
  logic [POS_W-1:0] bitPos;

  always_ff @(posedge clk) begin
    if (!rstN || !cfgMaster) begin
      divCnt <= '0;
      genBck <= 1'b0;
      bitPos <= '0;
    end else if (divCnt == cfgDiv) begin
      divCnt <= '0;
      genBck <= ~genBck;
      if (genBck) bitPos <= bitPos + 1'b1;   // advance on the non-sampling edge
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign sclkOut = cfgMaster & (genBck ^ cfgSclkInv);
  assign wclkOut = cfgMaster & (bitPos[POS_W-1] ^ cfgWclkInv);

  // Both modes share one sampled path, so clocks and data stay aligned.
  logic rawBck, rawWck;
  assign rawBck = cfgMaster ? sclkOut : sclkIn;
  assign rawWck = cfgMaster ? wclkOut : wclkIn;

  logic [SYNC_STAGES-1:0] syncB, syncW, syncD;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncB <= '0;
      syncW <= '0;
      syncD <= '0;
    end else begin
      syncB <= {syncB[SYNC_STAGES-2:0], rawBck};
      syncW <= {syncW[SYNC_STAGES-2:0], rawWck};
      syncD <= {syncD[SYNC_STAGES-2:0], sdIn};
    end
  end

  logic bckEff, chNow, prevBck, tick;
  assign bckEff = syncB[SYNC_STAGES-1] ^ cfgSclkInv;
  assign chNow  = syncW[SYNC_STAGES-1] ^ cfgWclkInv;   // 0: left, 1: right
  assign sdBit  = syncD[SYNC_STAGES-1];
  assign tick   = bckEff & ~prevBck;

  // Phase tracking
  logic              lastCh, armed, phaseStart;
  logic [SLOT_W-1:0] slotCnt, slotNow;
  logic [SLOT_W:0]   slotWide, firstSlot, endSlot;

  assign phaseStart = tick & (chNow != lastCh);
  assign slotNow    = phaseStart ? '0 : ((slotCnt == '1) ? slotCnt : slotCnt + 1'b1);
  assign slotWide   = {1'b0, slotNow};
  assign firstSlot  = (SLOT_W+1)'(cfgDelay);
  assign endSlot    = (SLOT_W+1)'(cfgBits) + firstSlot;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevBck <= 1'b1;
      lastCh  <= 1'b0;
      armed   <= 1'b0;
      slotCnt <= '0;
    end else begin
      prevBck <= bckEff;
      if (tick) begin
        lastCh  <= chNow;
        slotCnt <= slotNow;
        if (phaseStart) armed <= 1'b1;
      end
    end
  end

  always_comb begin
    strobe.tick       = tick;
    strobe.phaseStart = phaseStart;
    strobe.endValid   = phaseStart & armed;
    strobe.endedRight = lastCh;
    strobe.shiftBit   = tick & (cfgRightJust | ((slotWide >= firstSlot) && (slotWide < endSlot)));
  end
endmodule

// File: rtl/sarx_datapath.sv
module sarx_datapath
  import sarx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int BITS_W   = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  sarxStrobe_t         strobe,
  input  logic                sdBit,
  input  logic [BITS_W-1:0]   cfgBits,
  output logic [SAMPLE_W-1:0] leftOut,
  output logic [SAMPLE_W-1:0] rightOut,
  output logic                sampleValid
);
  localparam int IDX_W = $clog2(SAMPLE_W);

  logic [SAMPLE_W-1:0] shReg, ext, leftHold;
  logic                leftOk;
  logic [BITS_W-1:0]   nbEff;
  logic [IDX_W-1:0]    topIdx;

  assign nbEff  = (cfgBits == '0) ? BITS_W'(1)
                : (cfgBits > BITS_W'(SAMPLE_W)) ? BITS_W'(SAMPLE_W) : cfgBits;
  assign topIdx = IDX_W'(nbEff - 1'b1);

  // Sign extension from the configured resolution
  always_comb begin
    for (int i = 0; i < SAMPLE_W; i++) begin
      ext[i] = (i < int'(nbEff)) ? shReg[i] : shReg[topIdx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg       <= '0;
      leftHold    <= '0;
      leftOk      <= 1'b0;
      leftOut     <= '0;
      rightOut    <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= 1'b0;
      if (strobe.tick) begin
        if (strobe.endValid) begin
          if (!strobe.endedRight) begin
            leftHold <= ext;
            leftOk   <= 1'b1;
          end else if (leftOk) begin
            leftOut     <= leftHold;
            rightOut    <= ext;
            sampleValid <= 1'b1;
            leftOk      <= 1'b0;
          end
        end
        if (strobe.phaseStart) begin
          shReg <= strobe.shiftBit ? {{(SAMPLE_W-1){1'b0}}, sdBit} : '0;
        end else if (strobe.shiftBit) begin
          shReg <= {shReg[SAMPLE_W-2:0], sdBit};
        end
      end
    end
  end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sarx_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_BITS  = 64,
  parameter int BITS_W      = $clog2(SAMPLE_W + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgMaster,
  input  logic [DIV_W-1:0]    cfgDiv,
  input  logic [BITS_W-1:0]   cfgBits,
  input  logic                cfgRightJust,
  input  logic                cfgDelay,
  input  logic                cfgSclkInv,
  input  logic                cfgWclkInv,
  input  logic                sclkIn,
  input  logic                wclkIn,
  input  logic                sdIn,
  output logic                sclkOut,
  output logic                wclkOut,
  output logic [SAMPLE_W-1:0] leftOut,
  output logic [SAMPLE_W-1:0] rightOut,
  output logic                sampleValid
);
  localparam int SLOT_W = $clog2(FRAME_BITS);

  sarxStrobe_t strobe;
  logic        sdBit;

  sarx_ctrl #(
    .DIV_W(DIV_W), .BITS_W(BITS_W), .SYNC_STAGES(SYNC_STAGES),
    .FRAME_BITS(FRAME_BITS), .SLOT_W(SLOT_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .cfgMaster(cfgMaster), .cfgDiv(cfgDiv),
    .cfgBits(cfgBits), .cfgRightJust(cfgRightJust), .cfgDelay(cfgDelay),
    .cfgSclkInv(cfgSclkInv), .cfgWclkInv(cfgWclkInv),
    .sclkIn(sclkIn), .wclkIn(wclkIn), .sdIn(sdIn),
    .sclkOut(sclkOut), .wclkOut(wclkOut), .sdBit(sdBit), .strobe(strobe)
  );

  sarx_datapath #(.SAMPLE_W(SAMPLE_W), .BITS_W(BITS_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdBit(sdBit), .cfgBits(cfgBits),
    .leftOut(leftOut), .rightOut(rightOut), .sampleValid(sampleValid)
  );
endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk #(
  parameter int SAMPLE_W = 24,
  parameter int DIV_W    = 8,
  parameter int BITS_W   = 5
) (
  input logic                clk,
  input logic                rstN,
  input logic                cfgMaster,
  input logic [DIV_W-1:0]    cfgDiv,
  input logic [BITS_W-1:0]   cfgBits,
  input logic                cfgSclkInv,
  input logic [SAMPLE_W-1:0] leftOut,
  input logic [SAMPLE_W-1:0] rightOut,
  input logic                sampleValid,
  input logic                sclkOut,
  input logic                wclkOut
);
  function automatic logic signOk(input logic [SAMPLE_W-1:0] v, input logic [BITS_W-1:0] nb);
    int n;
    logic signed [SAMPLE_W-1:0] t;
    n = (nb == 0) ? 1 : ((int'(nb) > SAMPLE_W) ? SAMPLE_W : int'(nb));
    t = $signed(v) >>> (n - 1);
    return (t == '0) || (t == '1);
  endfunction

  // R8: the strobe lasts one cycle
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  // R8: outputs change only together with the strobe
  a_r8_hold_outputs: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |-> ($stable(leftOut) && $stable(rightOut)));

  // R5: presented samples are sign-extended from the configured width
  a_r5_sign_ext: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> (signOk(leftOut, cfgBits) && signOk(rightOut, cfgBits)));

  // R10: the generated word clock moves only on a non-sampling bit clock edge
  a_r10_wclk_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMaster && (wclkOut != $past(wclkOut)))
      |-> ($past(sclkOut ^ cfgSclkInv) && !(sclkOut ^ cfgSclkInv)));

  // R10: with a divider of 1 or more, no bit clock level is one cycle short
  a_r10_sclk_half_min: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMaster && (cfgDiv != '0) && (sclkOut != $past(sclkOut))) |=> $stable(sclkOut));
endmodule

bind serial_audio_rx serial_audio_rx_chk #(
  .SAMPLE_W(SAMPLE_W), .DIV_W(DIV_W), .BITS_W(BITS_W)
) uChk (
  .clk(clk), .rstN(rstN), .cfgMaster(cfgMaster), .cfgDiv(cfgDiv),
  .cfgBits(cfgBits), .cfgSclkInv(cfgSclkInv), .leftOut(leftOut),
  .rightOut(rightOut), .sampleValid(sampleValid), .sclkOut(sclkOut),
  .wclkOut(wclkOut)
);

// File: tb/sim_serial_audio_rx.sv
module sim_serial_audio_rx;
  localparam int CLK_PERIOD = 10;
  localparam int GAP        = 7;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgMaster = 1'b0;
  logic [7:0]  cfgDiv = 8'd2;
  logic [4:0]  cfgBits = 5'd16;
  logic        cfgRightJust = 1'b0, cfgDelay = 1'b0, cfgSclkInv = 1'b0, cfgWclkInv = 1'b0;
  logic        sclkIn = 1'b0, wclkIn = 1'b0, sdIn = 1'b0;
  logic        sclkOut, wclkOut, sampleValid;
  logic [23:0] leftOut, rightOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_audio_rx u0 (
    .clk(clk), .rstN(rstN), .cfgMaster(cfgMaster), .cfgDiv(cfgDiv), .cfgBits(cfgBits),
    .cfgRightJust(cfgRightJust), .cfgDelay(cfgDelay), .cfgSclkInv(cfgSclkInv),
    .cfgWclkInv(cfgWclkInv), .sclkIn(sclkIn), .wclkIn(wclkIn), .sdIn(sdIn),
    .sclkOut(sclkOut), .wclkOut(wclkOut), .leftOut(leftOut), .rightOut(rightOut),
    .sampleValid(sampleValid)
  );

  int    nCompared = 0, nMismatched = 0, nValid = 0;
  string curReq = "R1";
  logic [47:0] expQ[$];
  bit    finished = 0;
  int    halfT = 2;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
    nCompared++;
    if (!ok) begin
      nMismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] sext(input logic [23:0] v, input int n);
    logic [23:0] r;
    for (int i = 0; i < 24; i++) r[i] = (i < n) ? v[i] : v[n-1];
    return r;
  endfunction

  // Transmitter view: which bit a source puts in a given slot of a phase
  function automatic logic bitFor(input logic [23:0] v, input int n, input int slot,
                                  input int slots, input bit rj, input bit dly);
    int k;
    k = rj ? slot - (slots - n) : slot - int'(dly);
    if (k >= 0 && k < n) return v[n-1-k];
    return logic'(slot % 2);   // filler that must be ignored
  endfunction

  function automatic logic [23:0] pat(input int i);
    case (i % 8)
      0: return 24'h800001;
      1: return 24'h7FFFFF;
      2: return 24'h123456;
      3: return 24'hFEDCBA;
      4: return 24'h000000;
      5: return 24'hA5A5A5;
      6: return 24'h5A5A5A;
      default: return 24'hFFFFFF;
    endcase
  endfunction

  // Reference: every valid pulse is compared with the oldest frame sent
  always @(negedge clk) begin
    logic [47:0] e;
    if (rstN && sampleValid) begin
      nValid++;
      if (expQ.size() == 0) begin
        check(1'b0, curReq, "unexpected valid (R8)", {leftOut, rightOut}, 48'h0);
      end else begin
        e = expQ.pop_front();
        check({leftOut, rightOut} == e, curReq, "sample pair", {leftOut, rightOut}, e);
      end
    end
  end

  // Slave-mode source
  task automatic sendPhase(input bit chRight, input logic [23:0] v, input int slots,
                           input int gapEvery);
    for (int s = 0; s < slots; s++) begin
      sclkIn = cfgSclkInv;
      if (s == 0) wclkIn = chRight ^ cfgWclkInv;
      sdIn = bitFor(v, int'(cfgBits), s, slots, cfgRightJust, cfgDelay);
      repeat (halfT + ((gapEvery != 0 && (s % gapEvery) == gapEvery - 1) ? GAP : 0)) @(negedge clk);
      sclkIn = ~cfgSclkInv;
      repeat (halfT) @(negedge clk);
    end
  endtask

  task automatic sendFrame(input logic [23:0] l, input logic [23:0] r, input int slotsL,
                           input int slotsR, input int gapEvery);
    expQ.push_back({sext(l, int'(cfgBits)), sext(r, int'(cfgBits))});
    sendPhase(1'b0, l, slotsL, gapEvery);
    sendPhase(1'b1, r, slotsR, gapEvery);
  endtask

  // Master-mode source, following the port's own clocks
  bit          masterTx = 0;
  logic [23:0] mL[6], mR[6];
  int          mFrame, mSlot, cyc, rises;
  bit          mCh, prevEff, prevRaw, prevW, seenT, seenW;

  task automatic doReset(input bit m, input int div, input int n, input bit rj,
                         input bit dly, input bit sInv, input bit wInv);
    rstN = 1'b0;
    masterTx = 0;
    cfgMaster = m; cfgDiv = 8'(div); cfgBits = 5'(n); cfgRightJust = rj; cfgDelay = dly;
    cfgSclkInv = sInv; cfgWclkInv = wInv;
    sclkIn = sInv; wclkIn = 1'b1 ^ wInv; sdIn = 1'b0;
    expQ.delete();
    nValid = 0;
    mFrame = 0; mSlot = 0; mCh = 0; prevEff = 0; prevRaw = sInv; prevW = wInv;
    cyc = 0; rises = 0; seenT = 0; seenW = 0;
    for (int i = 0; i < 6; i++) begin
      mL[i] = pat(i * 3 + 1);
      mR[i] = pat(i * 5 + 2);
    end
    if (m) sdIn = bitFor(mL[0], n, 0, 32, rj, dly);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    masterTx = m;
  endtask

  always @(negedge clk) begin
    bit eff, wEff;
    if (masterTx && rstN) begin
      eff  = sclkOut ^ cfgSclkInv;
      wEff = wclkOut ^ cfgWclkInv;
      cyc++;
      if (sclkOut != prevRaw) begin
        if (seenT) check(cyc == int'(cfgDiv) + 1, curReq, "R10 bit clock half period",
                         48'(cyc), 48'(int'(cfgDiv) + 1));
        seenT = 1; cyc = 0;
      end
      prevRaw = sclkOut;
      if (eff && !prevEff) rises++;
      if (wEff != prevW) begin
        if (seenW) check(rises == 32, curReq, "R10 bit clocks per phase", 48'(rises), 48'd32);
        seenW = 1; rises = 0;
      end
      prevW = wEff;
      if (prevEff && !eff) begin
        if (wEff != mCh) begin
          mCh = wEff; mSlot = 0;
          if (!wEff) mFrame++;
        end else begin
          mSlot++;
        end
        if (mFrame < 6)
          sdIn = bitFor(mCh ? mR[mFrame] : mL[mFrame], int'(cfgBits), mSlot, 32,
                        cfgRightJust, cfgDelay);
      end
      prevEff = eff;
    end
  end

  task automatic runSlave(input string req, input int n, input bit rj, input bit dly,
                          input bit sInv, input bit wInv, input int h, input int slotsL,
                          input int slotsR, input int gapEvery);
    curReq = req;
    halfT = h;
    doReset(1'b0, 2, n, rj, dly, sInv, wInv);
    sendPhase(1'b1, 24'h0, 2, 0);                 // lead-in right phase arms the port
    for (int f = 0; f < 5; f++) sendFrame(pat(f), pat(f + 3), slotsL, slotsR, gapEvery);
    sendPhase(1'b0, 24'h0, 1, 0);                 // first slot of the next left phase
    sclkIn = cfgSclkInv;
    repeat (12) @(negedge clk);
    check(expQ.size() == 0 && nValid == 5, req, "R8 one pulse per frame",
          48'(nValid), 48'd5);
  endtask

  task automatic runMaster(input string req, input int div, input int n, input bit rj,
                           input bit dly, input bit sInv, input bit wInv);
    curReq = req;
    doReset(1'b1, div, n, rj, dly, sInv, wInv);
    // Frame 0 is not delivered (R8): the first change arms, the first full left follows
    for (int f = 1; f < 5; f++) expQ.push_back({sext(mL[f], n), sext(mR[f], n)});
    wait (mFrame == 5);
    repeat (12) @(negedge clk);
    check(expQ.size() == 0 && nValid == 4, req, "R8 pulses in master mode",
          48'(nValid), 48'd4);
    masterTx = 0;
  endtask

  initial begin
    doReset(1'b0, 2, 16, 1'b0, 1'b1, 1'b0, 1'b0);
    // R1: reset state at the ports
    check(sampleValid == 1'b0, "R1", "valid after reset", 48'(sampleValid), 48'h0);
    check(leftOut == 24'h0 && rightOut == 24'h0, "R1", "samples after reset",
          {leftOut, rightOut}, 48'h0);
    check(sclkOut == 1'b0 && wclkOut == 1'b0, "R1", "slave clock outputs",
          48'({sclkOut, wclkOut}), 48'h0);
    runSlave("R3/R5",    16, 1'b0, 1'b1, 1'b0, 1'b0, 2, 32, 32, 0);
    runSlave("R2/R9",    24, 1'b0, 1'b0, 1'b0, 1'b0, 3, 24, 40, 3);
    runSlave("R4/R6/R7", 20, 1'b1, 1'b1, 1'b1, 1'b1, 2, 32, 32, 0);
    runSlave("R2/R5",     8, 1'b0, 1'b0, 1'b0, 1'b0, 2, 20, 13, 0);
    runSlave("R4/R9",    24, 1'b1, 1'b0, 1'b0, 1'b1, 2, 24, 28, 5);
    runSlave("R5/R6",     1, 1'b0, 1'b1, 1'b1, 1'b0, 2, 4, 3, 0);
    runMaster("R10/R11",    2, 24, 1'b0, 1'b1, 1'b0, 1'b0);
    runMaster("R6/R7/R11",  1, 16, 1'b1, 1'b0, 1'b1, 1'b1);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(1'b0, curReq, "watchdog expired", 48'h0, 48'h1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
      $finish;
    end
  end
endmodule